// File: doc/BRIEF.md
# Write-Back Update-Protocol Cache Controller

This block is the coherence controller of one private cache in a snooping multiprocessor. Each cache keeps its lines in one of four states: clean and alone (EC), clean and shared (SC), dirty and shared with this cache as owner (SM), or dirty and alone (MD). A line that is absent is "not present". There is no invalid state reached by snooping, because a write to shared data never removes other copies. The writer broadcasts the written word, and every other holder patches its own copy. Storage is a small direct-mapped register array. A CPU address splits into `{tag, set index, word offset}`. The word with offset `o` sits in bits `[o*DW +: DW]` of a line.

The controller acts as a bus master when it is granted, and as a snooper of every other cache's transfer. The bus command codes are 0 = idle, 1 = line read, 2 = word update, and 3 = write-back of a victim line. Caches that hold a line matching the address on the bus raise `shr_out`. The system ORs these into every other cache's `shr_in`. A dirty holder of a line that is read supplies the whole line on `own_line` with `own_out`. When nobody supplies the line, memory does. Memory changes only on a write-back.

A CPU request is held until `cpu_done` pulses. Read hits, and write hits on an EC or MD line, finish locally. All other accesses request the bus.

Top module: `updc_ctrl`

## Requirements
- R1: After reset every line is not present. `cpu_done`, `bus_req` and `mst_cmd` are 0, and the first read of any address issues a line read (code 1) and returns the memory word.
- R2: A read miss while `shr_in` is low installs the line as EC. A later write to it completes with no bus transfer.
- R3: A read miss while `shr_in` is high installs the line as SC. A cache holding a matching line raises `shr_out` during another cache's line read or word update.
- R4: A write hit on an SC or SM line issues exactly one word update (code 2) with the address and word. Every other holder writes that word and takes SC, so its next read returns the new word with no bus transfer.
- R5: After issuing a word update, the writer takes SM if `shr_in` was high in that cycle, so its next write again updates. Otherwise it takes MD, so its next write makes no bus transfer.
- R6: A write miss issues a line read. If `shr_in` is high, it then issues a word update (two transfers) and the line becomes SM. Otherwise the line becomes MD after one transfer.
- R7: A snooped line read that hits an MD or SM line raises `own_out`, drives the current line on `own_line`, and leaves the line SM. At most one cache supplies a line at a time.
- R8: A snooped line read that hits an EC line moves it to SC without supplying data, so the holder's next write issues a word update.
- R9: A miss whose set holds an MD or SM victim first writes it back (code 3, victim address and line), then issues the line read. An EC or SC victim is dropped with no write-back.
- R10: A write to an SC or SM line changes no local data before the bus is granted. A line read by another cache while the write waits returns the old word.
- R11: The controller drives a command only while granted, and holds `bus_req` until it is served. `cpu_done` is a one-cycle pulse, with read data valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address {tag, index, offset} |
| cpu_wdata | input | DW | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read word, valid with cpu_done |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mst_cmd | output | 2 | Command driven when granted |
| mst_addr | output | AW | Address driven when granted |
| mst_line | output | LW | Victim line for write-back |
| mst_word | output | DW | Word for update |
| snp_cmd | input | 2 | Command currently on the bus |
| snp_addr | input | AW | Address currently on the bus |
| snp_word | input | DW | Update word currently on the bus |
| shr_in | input | 1 | OR of other caches' shr_out |
| shr_out | output | 1 | This cache holds the snooped line |
| own_out | output | 1 | This cache supplies the snooped line |
| own_line | output | LW | Supplied line data |
| fill_line | input | LW | Resolved line on the bus (supplier or memory) |

## Verification
The assertions assume a single bus. Only the granted cache drives it, and the grant stays with that cache while it keeps requesting. `snp_cmd`/`snp_addr` mirror the granted master, and `shr_in` is the OR of the other caches' `shr_out`. They also assume the CPU holds its request fields steady until `cpu_done`. The bench meets these assumptions with three controllers behind a hold-while-requesting arbiter and a combinational bus resolver. Its driver issues one CPU access at a time. The one exception is the deliberately stalled write, whose grant is masked while another cache reads the same line.

// File: rtl/updc_pkg.sv
package updc_pkg;
  typedef enum logic [2:0] {
    LN_NP = 3'd0,
    LN_EC = 3'd1,
    LN_SC = 3'd2,
    LN_SM = 3'd3,
    LN_MD = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    BC_IDLE = 2'd0,
    BC_READ = 2'd1,
    BC_UPD  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_BUSY = 2'd1,
    MS_ACK  = 2'd2
  } mst_fsm_e;
endpackage

// File: rtl/updc_store.sv
module updc_store
  import updc_pkg::*;
#(
  parameter int TAG_W = 2,
  parameter int IDX_W = 2,
  parameter int OFS_W = 1,
  parameter int DW    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            a_idx,
  output line_st_e                    a_st,
  output logic [TAG_W-1:0]            a_tag,
  output logic [(DW<<OFS_W)-1:0]      a_line,
  input  logic [IDX_W-1:0]            b_idx,
  output line_st_e                    b_st,
  output logic [TAG_W-1:0]            b_tag,
  output logic [(DW<<OFS_W)-1:0]      b_line,
  input  logic                        w_en,
  input  logic [IDX_W-1:0]            w_idx,
  input  line_st_e                    w_st,
  input  logic                        w_tag_en,
  input  logic [TAG_W-1:0]            w_tag,
  input  logic                        w_line_en,
  input  logic [(DW<<OFS_W)-1:0]      w_line,
  input  logic                        w_word_en,
  input  logic [OFS_W-1:0]            w_ofs,
  input  logic [DW-1:0]               w_word
);
  localparam int NSET = 1 << IDX_W;
  localparam int LW   = DW << OFS_W;

  line_st_e         st_q   [NSET];
  logic [TAG_W-1:0] tag_q  [NSET];
  logic [LW-1:0]    line_q [NSET];

  for (genvar s = 0; s < NSET; s++) begin : g_set
    logic sel;
    assign sel = w_en && (w_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q[s] <= LN_NP;
      else if (sel) st_q[s] <= w_st;
    end

    always_ff @(posedge clk) begin
      if (sel && w_tag_en) tag_q[s] <= w_tag;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        if (w_line_en)      line_q[s] <= w_line;
        else if (w_word_en) line_q[s][int'(w_ofs)*DW +: DW] <= w_word;
      end
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_line = line_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_line = line_q[b_idx];
endmodule

// File: rtl/updc_snoop.sv
module updc_snoop
  import updc_pkg::*;
#(
  parameter int TAG_W = 2,
  parameter int DW    = 8,
  parameter int LW    = 16
) (
  input  logic             bus_gnt,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_e         b_st,
  input  logic [TAG_W-1:0] b_tag,
  input  logic [LW-1:0]    b_line,
  output logic             snoop_act,
  output logic             shr_out,
  output logic             own_out,
  output logic [LW-1:0]    own_line,
  output logic             sw_en,
  output line_st_e         sw_st,
  output logic             sw_word_en
);
  logic hit;
  assign snoop_act = (bus_cmd_e'(snp_cmd) != BC_IDLE) && !bus_gnt;
  assign hit       = (b_st != LN_NP) && (b_tag == snp_tag);
  assign own_line  = b_line;

  always_comb begin
    shr_out    = 1'b0;
    own_out    = 1'b0;
    sw_en      = 1'b0;
    sw_st      = b_st;
    sw_word_en = 1'b0;
    if (snoop_act && hit) begin
      unique case (bus_cmd_e'(snp_cmd))
        BC_READ: begin
          shr_out = 1'b1;
          if (b_st == LN_MD || b_st == LN_SM) begin
            own_out = 1'b1;
            sw_en   = 1'b1;
            sw_st   = LN_SM;
          end else if (b_st == LN_EC) begin
            sw_en = 1'b1;
            sw_st = LN_SC;
          end
        end
        BC_UPD: begin
          shr_out = 1'b1;
          if (b_st == LN_SC || b_st == LN_SM) begin
            sw_en      = 1'b1;
            sw_word_en = 1'b1;
            sw_st      = LN_SC;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/updc_master.sv
module updc_master
  import updc_pkg::*;
#(
  parameter int TAG_W = 2,
  parameter int IDX_W = 2,
  parameter int OFS_W = 1,
  parameter int DW    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [TAG_W+IDX_W+OFS_W-1:0] cpu_addr,
  input  logic [DW-1:0]          cpu_wdata,
  output logic                   cpu_done,
  output logic [DW-1:0]          cpu_rdata,
  input  logic                   bus_gnt,
  input  logic                   shr_in,
  input  logic [(DW<<OFS_W)-1:0] fill_line,
  input  logic                   snoop_act,
  input  line_st_e               a_st,
  input  logic [TAG_W-1:0]       a_tag,
  input  logic [(DW<<OFS_W)-1:0] a_line,
  output logic                   bus_req,
  output bus_cmd_e               mst_cmd,
  output logic [TAG_W+IDX_W+OFS_W-1:0] mst_addr,
  output logic [(DW<<OFS_W)-1:0] mst_line,
  output logic [DW-1:0]          mst_word,
  output logic                   mwr_en,
  output line_st_e               mwr_st,
  output logic                   mwr_tag_en,
  output logic [TAG_W-1:0]       mwr_tag,
  output logic                   mwr_line_en,
  output logic [(DW<<OFS_W)-1:0] mwr_line,
  output logic                   mwr_word_en,
  output logic [DW-1:0]          mwr_word
);
  localparam int AW = TAG_W + IDX_W + OFS_W;
  localparam int LW = DW << OFS_W;

  mst_fsm_e         fsm_q, fsm_d;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic             rdata_en;

  logic [TAG_W-1:0] c_tag;
  logic [IDX_W-1:0] c_idx;
  logic [OFS_W-1:0] c_ofs;
  logic             present, hit, dirty_vict, shared_ln;
  logic [DW-1:0]    hit_word, fill_word;
  logic [LW-1:0]    fill_mrg;

  assign c_tag      = cpu_addr[AW-1 -: TAG_W];
  assign c_idx      = cpu_addr[OFS_W +: IDX_W];
  assign c_ofs      = cpu_addr[OFS_W-1:0];
  assign present    = (a_st != LN_NP);
  assign hit        = present && (a_tag == c_tag);
  assign dirty_vict = present && !hit && (a_st == LN_MD || a_st == LN_SM);
  assign shared_ln  = (a_st == LN_SC || a_st == LN_SM);
  assign hit_word   = a_line[int'(c_ofs)*DW +: DW];
  assign fill_word  = fill_line[int'(c_ofs)*DW +: DW];

  always_comb begin
    fill_mrg = fill_line;
    fill_mrg[int'(c_ofs)*DW +: DW] = cpu_wdata;
  end

  always_comb begin
    fsm_d       = fsm_q;
    rdata_en    = 1'b0;
    rdata_d     = rdata_q;
    mst_cmd     = BC_IDLE;
    mst_addr    = '0;
    mst_line    = '0;
    mst_word    = '0;
    mwr_en      = 1'b0;
    mwr_st      = a_st;
    mwr_tag_en  = 1'b0;
    mwr_tag     = c_tag;
    mwr_line_en = 1'b0;
    mwr_line    = fill_line;
    mwr_word_en = 1'b0;
    mwr_word    = cpu_wdata;
    unique case (fsm_q)
      MS_IDLE: begin
        if (cpu_req && !snoop_act) begin
          if (hit && !cpu_we) begin
            rdata_en = 1'b1;
            rdata_d  = hit_word;
            fsm_d    = MS_ACK;
          end else if (hit && (a_st == LN_EC || a_st == LN_MD)) begin
            mwr_en      = 1'b1;
            mwr_word_en = 1'b1;
            mwr_st      = LN_MD;
            fsm_d       = MS_ACK;
          end else begin
            fsm_d = MS_BUSY;
          end
        end
      end
      MS_BUSY: begin
        if (bus_gnt) begin
          if (dirty_vict) begin
            mst_cmd  = BC_WB;
            mst_addr = {a_tag, c_idx, {OFS_W{1'b0}}};
            mst_line = a_line;
            mwr_en   = 1'b1;
            mwr_st   = LN_NP;
          end else if (!hit) begin
            mst_cmd     = BC_READ;
            mst_addr    = {c_tag, c_idx, {OFS_W{1'b0}}};
            mwr_en      = 1'b1;
            mwr_tag_en  = 1'b1;
            mwr_line_en = 1'b1;
            if (!cpu_we) begin
              mwr_st   = shr_in ? LN_SC : LN_EC;
              rdata_en = 1'b1;
              rdata_d  = fill_word;
              fsm_d    = MS_ACK;
            end else if (shr_in) begin
              mwr_st = LN_SC;
            end else begin
              mwr_st   = LN_MD;
              mwr_line = fill_mrg;
              fsm_d    = MS_ACK;
            end
          end else if (cpu_we && shared_ln) begin
            mst_cmd     = BC_UPD;
            mst_addr    = cpu_addr;
            mst_word    = cpu_wdata;
            mwr_en      = 1'b1;
            mwr_word_en = 1'b1;
            mwr_st      = shr_in ? LN_SM : LN_MD;
            fsm_d       = MS_ACK;
          end else if (cpu_we) begin
            mwr_en      = 1'b1;
            mwr_word_en = 1'b1;
            mwr_st      = LN_MD;
            fsm_d       = MS_ACK;
          end else begin
            rdata_en = 1'b1;
            rdata_d  = hit_word;
            fsm_d    = MS_ACK;
          end
        end
      end
      default: fsm_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsm_q <= MS_IDLE;
    else        fsm_q <= fsm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign bus_req   = (fsm_q == MS_BUSY);
  assign cpu_done  = (fsm_q == MS_ACK);
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/updc_ctrl.sv
module updc_ctrl
  import updc_pkg::*;
#(
  parameter int TAG_W = 2,
  parameter int IDX_W = 2,
  parameter int OFS_W = 1,
  parameter int DW    = 8,
  localparam int AW   = TAG_W + IDX_W + OFS_W,
  localparam int LW   = DW << OFS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    mst_cmd,
  output logic [AW-1:0] mst_addr,
  output logic [LW-1:0] mst_line,
  output logic [DW-1:0] mst_word,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_word,
  input  logic          shr_in,
  output logic          shr_out,
  output logic          own_out,
  output logic [LW-1:0] own_line,
  input  logic [LW-1:0] fill_line
);
  line_st_e         a_st, b_st, sw_st, mwr_st, w_st;
  logic [TAG_W-1:0] a_tag, b_tag, mwr_tag;
  logic [LW-1:0]    a_line, b_line, mwr_line;
  logic             snoop_act, sw_en, sw_word_en;
  logic             mwr_en, mwr_tag_en, mwr_line_en, mwr_word_en;
  logic [DW-1:0]    mwr_word;
  bus_cmd_e         cmd_e;
  logic             w_en, w_word_en;
  logic [IDX_W-1:0] w_idx;
  logic [OFS_W-1:0] w_ofs;
  logic [DW-1:0]    w_word;

  updc_master #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .DW(DW)) u_mst (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_gnt(bus_gnt), .shr_in(shr_in), .fill_line(fill_line), .snoop_act(snoop_act),
    .a_st(a_st), .a_tag(a_tag), .a_line(a_line),
    .bus_req(bus_req), .mst_cmd(cmd_e), .mst_addr(mst_addr), .mst_line(mst_line),
    .mst_word(mst_word),
    .mwr_en(mwr_en), .mwr_st(mwr_st), .mwr_tag_en(mwr_tag_en), .mwr_tag(mwr_tag),
    .mwr_line_en(mwr_line_en), .mwr_line(mwr_line), .mwr_word_en(mwr_word_en),
    .mwr_word(mwr_word)
  );
  assign mst_cmd = cmd_e;

  updc_snoop #(.TAG_W(TAG_W), .DW(DW), .LW(LW)) u_snp (
    .bus_gnt(bus_gnt), .snp_cmd(snp_cmd), .snp_tag(snp_addr[AW-1 -: TAG_W]),
    .b_st(b_st), .b_tag(b_tag), .b_line(b_line),
    .snoop_act(snoop_act), .shr_out(shr_out), .own_out(own_out), .own_line(own_line),
    .sw_en(sw_en), .sw_st(sw_st), .sw_word_en(sw_word_en)
  );

  assign w_en      = snoop_act ? sw_en      : mwr_en;
  assign w_idx     = snoop_act ? snp_addr[OFS_W +: IDX_W] : cpu_addr[OFS_W +: IDX_W];
  assign w_st      = snoop_act ? sw_st      : mwr_st;
  assign w_word_en = snoop_act ? sw_word_en : mwr_word_en;
  assign w_ofs     = snoop_act ? snp_addr[OFS_W-1:0] : cpu_addr[OFS_W-1:0];
  assign w_word    = snoop_act ? snp_word   : mwr_word;

  updc_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(cpu_addr[OFS_W +: IDX_W]), .a_st(a_st), .a_tag(a_tag), .a_line(a_line),
    .b_idx(snp_addr[OFS_W +: IDX_W]), .b_st(b_st), .b_tag(b_tag), .b_line(b_line),
    .w_en(w_en), .w_idx(w_idx), .w_st(w_st),
    .w_tag_en(!snoop_act && mwr_tag_en), .w_tag(mwr_tag),
    .w_line_en(!snoop_act && mwr_line_en), .w_line(mwr_line),
    .w_word_en(w_word_en), .w_ofs(w_ofs), .w_word(w_word)
  );
endmodule

// File: rtl/updc_chk.sv
module updc_chk
  import updc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_done,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [1:0] mst_cmd,
  input logic [1:0] snp_cmd,
  input logic       shr_out,
  input logic       own_out,
  input line_st_e   a_st,
  input logic       mwr_en,
  input logic       mwr_word_en,
  input logic       sw_en
);
  AST_CMD_ONLY_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_cmd != 2'd0) |-> bus_gnt); // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R11
  AST_SHARED_ON_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    shr_out |-> (!bus_gnt && (snp_cmd == 2'd1 || snp_cmd == 2'd2))); // R3
  AST_SUPPLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    own_out |-> (snp_cmd == 2'd1 && shr_out)); // R7
  AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_en && mwr_word_en && (a_st == LN_SC || a_st == LN_SM))
      |-> (bus_gnt && mst_cmd == 2'd2)); // R10
  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en && mwr_en && !bus_gnt && snp_cmd != 2'd0)); // R4
endmodule

bind updc_ctrl updc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .mst_cmd(mst_cmd), .snp_cmd(snp_cmd), .shr_out(shr_out),
  .own_out(own_out), .a_st(a_st), .mwr_en(mwr_en), .mwr_word_en(mwr_word_en),
  .sw_en(sw_en)
);

// File: tb/updc_ctrl_tb.sv
`timescale 1ns/1ps
module updc_ctrl_tb;
  localparam int TAG_W = 2, IDX_W = 2, OFS_W = 1, DW = 8;
  localparam int AW = TAG_W + IDX_W + OFS_W;
  localparam int LW = DW << OFS_W;
  localparam int NC = 3;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic          cpu_req   [NC];
  logic          cpu_we    [NC];
  logic [AW-1:0] cpu_addr  [NC];
  logic [DW-1:0] cpu_wdata [NC];
  logic          cpu_done  [NC];
  logic [DW-1:0] cpu_rdata [NC];
  logic          bus_req   [NC];
  logic          gnt       [NC];
  logic [1:0]    mst_cmd   [NC];
  logic [AW-1:0] mst_addr  [NC];
  logic [LW-1:0] mst_line  [NC];
  logic [DW-1:0] mst_word  [NC];
  logic          shr_in    [NC];
  logic          shr_out   [NC];
  logic          own_out   [NC];
  logic [LW-1:0] own_line  [NC];
  logic          blk       [NC];
  logic          rd_flag   [NC];

  logic [1:0]    bcmd;
  logic [AW-1:0] baddr;
  logic [LW-1:0] bline;
  logic [DW-1:0] bword;
  logic [LW-1:0] fill;
  logic [LW-1:0] mem [NA/2];
  logic          gnt_v;
  int            gnt_id;

  for (genvar c = 0; c < NC; c++) begin : g_c
    updc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req[c]), .cpu_we(cpu_we[c]), .cpu_addr(cpu_addr[c]),
      .cpu_wdata(cpu_wdata[c]), .cpu_done(cpu_done[c]), .cpu_rdata(cpu_rdata[c]),
      .bus_req(bus_req[c]), .bus_gnt(gnt[c]),
      .mst_cmd(mst_cmd[c]), .mst_addr(mst_addr[c]), .mst_line(mst_line[c]),
      .mst_word(mst_word[c]),
      .snp_cmd(bcmd), .snp_addr(baddr), .snp_word(bword),
      .shr_in(shr_in[c]), .shr_out(shr_out[c]), .own_out(own_out[c]),
      .own_line(own_line[c]), .fill_line(fill)
    );
  end

  // arbiter: holder keeps the bus while requesting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_v  <= 1'b0;
      gnt_id <= 0;
    end else if (!gnt_v || !bus_req[gnt_id]) begin
      gnt_v <= 1'b0;
      for (int k = NC - 1; k >= 0; k--)
        if (bus_req[k] && !blk[k]) begin
          gnt_v  <= 1'b1;
          gnt_id <= k;
        end
    end
  end

  always_comb begin
    for (int c = 0; c < NC; c++) gnt[c] = gnt_v && (gnt_id == c);
    bcmd = '0; baddr = '0; bline = '0; bword = '0;
    if (gnt_v) begin
      bcmd  = mst_cmd[gnt_id];
      baddr = mst_addr[gnt_id];
      bline = mst_line[gnt_id];
      bword = mst_word[gnt_id];
    end
    fill = mem[baddr[AW-1:OFS_W]];
    for (int k = 0; k < NC; k++) if (own_out[k]) fill = own_line[k];
    for (int c = 0; c < NC; c++) begin
      shr_in[c] = 1'b0;
      for (int k = 0; k < NC; k++) if (k != c && shr_out[k]) shr_in[c] = 1'b1;
    end
  end

  int n_chk = 0, n_bad = 0, txn_cnt = 0;
  bit multi_own = 1'b0;
  int cmd_log[$];
  logic [DW-1:0] gold [NA];

  typedef struct { int c; int a; int d; string rq; } sb_t;
  sb_t sb_q[$];

  function automatic logic [DW-1:0] init_w(input int a);
    return DW'((a * 7 + 3) & 8'hff);
  endfunction

  // memory: changes only on write-back; bus transfer log
  always @(posedge clk) begin
    if (rst_n) begin
      int nown;
      if (bcmd == 2'd3) mem[baddr[AW-1:OFS_W]] <= bline;
      if (bcmd != 2'd0) begin
        txn_cnt++;
        cmd_log.push_back(int'(bcmd));
      end
      nown = 0;
      for (int k = 0; k < NC; k++) if (own_out[k]) nown++;
      if (nown > 1) multi_own = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard items when a read completes
  always @(negedge clk) begin
    for (int c = 0; c < NC; c++) begin
      if (rst_n && cpu_done[c] && rd_flag[c]) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected read completion", c, -1);
        end else begin
          sb_t e;
          e = sb_q.pop_front();
          chk(e.c == c && int'(cpu_rdata[c]) == e.d, e.rq,
              $sformatf("read cache%0d addr%0d", c, e.a), int'(cpu_rdata[c]), e.d);
        end
      end
    end
  end

  task automatic wait_done(input int c, input string rq);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cpu_done[c] && n < 2000);
    if (!cpu_done[c]) chk(1'b0, rq, "completion timeout", 0, 1);
  endtask

  task automatic op(input int c, input bit we, input int a, input int wd,
                    input int exp_n, input int exp_c0, input string rq);
    int t0;
    t0 = txn_cnt;
    cmd_log.delete();
    if (!we) begin
      sb_q.push_back('{c: c, a: a, d: int'(gold[a]), rq: rq});
      rd_flag[c] = 1'b1;
    end
    @(negedge clk);
    cpu_req[c] = 1'b1; cpu_we[c] = we;
    cpu_addr[c] = AW'(a); cpu_wdata[c] = DW'(wd);
    wait_done(c, rq);
    cpu_req[c] = 1'b0;
    if (we) gold[a] = DW'(wd);
    @(negedge clk);
    rd_flag[c] = 1'b0;
    if (exp_n >= 0) chk(txn_cnt - t0 == exp_n, rq, "bus transfers", txn_cnt - t0, exp_n);
    if (exp_c0 >= 0)
      chk(cmd_log.size() > 0 && cmd_log[0] == exp_c0, rq, "first command",
          cmd_log.size() > 0 ? cmd_log[0] : -1, exp_c0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int a = 0; a < NA; a++) gold[a] = init_w(a);
    for (int l = 0; l < NA / 2; l++) mem[l] = {init_w(2 * l + 1), init_w(2 * l)};
    for (int c = 0; c < NC; c++) begin
      cpu_req[c] = 1'b0; cpu_we[c] = 1'b0; cpu_addr[c] = '0; cpu_wdata[c] = '0;
      blk[c] = 1'b0; rd_flag[c] = 1'b0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NC; c++)
      chk(!cpu_done[c] && !bus_req[c] && mst_cmd[c] == 2'd0, "R1", "reset outputs",
          int'(cpu_done[c]) + int'(bus_req[c]) + int'(mst_cmd[c]), 0);

    op(0, 0, 5, 0, 1, 1, "R1");          // first read: line read, memory value
    op(0, 1, 5, 8'h55, 0, -1, "R2");     // EC -> MD silently
    op(1, 0, 5, 0, 1, 1, "R7");          // MD owner supplies 0x55
    chk(!multi_own, "R7", "single supplier", int'(multi_own), 0);
    op(1, 1, 5, 8'h66, 1, 2, "R4");      // SC write -> update
    op(0, 0, 5, 0, 0, -1, "R4");         // other copy patched, local hit
    op(1, 1, 5, 8'h67, 1, 2, "R5");      // SM with sharer -> update again
    op(2, 0, 9, 0, 1, 1, "R2");          // EC in cache2
    op(0, 0, 9, 0, 1, 1, "R3");          // shared -> SC, cache2 EC -> SC
    op(2, 1, 9, 8'h77, 1, 2, "R8");      // former EC now updates
    op(0, 0, 9, 0, 0, -1, "R4");
    op(0, 1, 12, 8'h21, 1, 1, "R6");     // write miss alone, SC victim dropped (R9)
    op(0, 1, 12, 8'h22, 0, -1, "R6");    // now MD
    op(1, 1, 9, 8'h88, 2, 1, "R6");      // write miss with sharers: read+update
    op(2, 0, 9, 0, 0, -1, "R6");
    op(0, 0, 9, 0, 0, -1, "R4");
    op(1, 1, 5, 8'h68, 1, 2, "R5");      // no sharer left -> MD
    op(1, 1, 5, 8'h69, 0, -1, "R5");
    op(1, 0, 21, 0, 2, 3, "R9");         // dirty victim written back first
    op(2, 0, 5, 0, 1, 1, "R9");          // memory now holds 0x69
    op(2, 0, 12, 0, 1, 1, "R7");         // cache0 MD -> SM, supplies 0x22

    // R10: stalled write must not leak before grant
    begin
      int t0;
      blk[0] = 1'b1;
      @(negedge clk);
      cpu_req[0] = 1'b1; cpu_we[0] = 1'b1; cpu_addr[0] = AW'(12); cpu_wdata[0] = 8'h99;
      repeat (4) @(negedge clk);
      op(1, 0, 12, 0, 1, 1, "R10");      // must see old 0x22
      t0 = txn_cnt;
      blk[0] = 1'b0;
      wait_done(0, "R10");
      cpu_req[0] = 1'b0;
      gold[12] = 8'h99;
      @(negedge clk);
      chk(txn_cnt - t0 == 1 && cmd_log[cmd_log.size() - 1] == 2, "R10",
          "stalled write issued update", txn_cnt - t0, 1);
    end
    op(1, 0, 12, 0, 0, -1, "R4");
    op(2, 0, 12, 0, 0, -1, "R4");
    op(0, 1, 12, 8'h9a, 1, 2, "R5");     // SM with sharers keeps updating

    // all copies agree
    for (int c = 0; c < NC; c++) begin
      op(c, 0, 5, 0, -1, -1, "R4");
      op(c, 0, 9, 0, -1, -1, "R4");
      op(c, 0, 12, 0, -1, -1, "R4");
    end
    chk(!multi_own, "R7", "single supplier overall", int'(multi_own), 0);
    chk(sb_q.size() == 0, "R11", "scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule